// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a set of interrupt request wires into a vector of pending bits. A per-line trigger-mode bit chooses how each line is captured. A level-mode line mirrors its wire. An edge-mode line records a low-to-high transition and keeps that record until it is cleared. To find edges, each line keeps a one-bit copy of the level it saw on the previous clock.

A priority resolver downstream reads the pending vector. When it grants a line, it sends back an acknowledge strobe with the line number. An initialization strobe returns the capture state to a known point without losing requests that are still asserted on level lines. Each line also has a one-cycle "newly raised" flag that tells the resolver a fresh request has arrived. That flag stays quiet while the line is masked, even though the pending bit still sets.

The trigger-mode register has a fixed per-instance writable mask, so some lines can never be switched to level mode. A primary instance typically uses mask 0xF8 and a secondary instance uses 0xDE.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose mode bit is 1 (level) has its pending bit equal to its request input as sampled at the previous clock edge, so it sets while the input is high and clears the cycle after the input drops.
- R2: A line whose mode bit is 0 (edge) sets its pending bit only when the input is high and the line's stored previous level is low. An input held high after the bit was cleared does not set it again.
- R3: A low request input never clears the pending bit of an edge-mode line.
- R4: When an acknowledge is strobed with line index k, the pending bit of line k is cleared if line k is edge mode and left unchanged if it is level mode. Other lines are not affected. If a new rising edge arrives on line k in the same cycle, that edge wins and the bit stays set.
- R5: Initialization clears every stored previous level to 0, clears the pending bits of edge-mode lines and keeps the pending bits of level-mode lines. As a result, an edge-mode line still held high sets again in the cycle after initialization.
- R6: A write to the trigger-mode register stores the written value ANDed with the instance's writable mask (parameter, default 0xF8). The stored value is visible on `mode_o`.
- R7: `raised_o[i]` is high for exactly one cycle, the cycle in which `pending_o[i]` first becomes 1. It stays low if `mask_i[i]` was 1 in the sampling cycle, although the pending bit still sets.
- R8: Synchronous active-high reset clears the pending bits, the previous levels, the mode register and the raised flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_LINES | Request levels, already synchronous to clk |
| mode_we | input | 1 | Trigger-mode register write strobe |
| mode_wdata | input | N_LINES | Trigger-mode write data, 1 = level, 0 = edge |
| mask_i | input | N_LINES | Per-line mask, 1 suppresses the raised flag |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Index of the acknowledged line |
| init_pulse | input | 1 | Initialization strobe |
| pending_o | output | N_LINES | Pending request vector |
| mode_o | output | N_LINES | Current trigger-mode register |
| raised_o | output | N_LINES | One-cycle newly-raised flags, masked |

## Verification
The main instance uses eight lines and the 0xF8 mask. With that mask, line 0 is forced to edge mode and line 3 can be switched to level mode, so both capture paths run side by side under the same acknowledge and initialization strobes. A second instance uses the 0xDE mask, which exercises the other writable pattern, where bits 0 and 5 are fixed to edge mode.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] TRIG_WMASK = 8'hF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)     mode_q <= '0;
    else if (we) mode_q <= wdata & TRIG_WMASK;
  end
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               valid,
  input  logic [IDX_W-1:0]   idx,
  output logic [N_LINES-1:0] hit
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_hit
    assign hit[g] = valid && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  trig_mode_e mode,
  input  logic       ack_hit,
  input  logic       init,
  input  logic       mask,
  output logic       pend_q,
  output logic       raised_q
);
  logic last_q;
  logic pend_d;

  always_comb begin
    if (init)
      pend_d = pend_q && (mode == TRIG_LEVEL);
    else if (mode == TRIG_LEVEL)
      pend_d = req;
    else
      pend_d = (pend_q && !ack_hit) || (req && !last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      last_q   <= 1'b0;
      raised_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      last_q   <= init ? 1'b0 : req;
      raised_q <= !init && !mask && !pend_q && pend_d;
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] TRIG_WMASK = 8'hF8,
  localparam int                IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_i,
  input  logic               mode_we,
  input  logic [N_LINES-1:0] mode_wdata,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_idx,
  input  logic               init_pulse,
  output logic [N_LINES-1:0] pending_o,
  output logic [N_LINES-1:0] mode_o,
  output logic [N_LINES-1:0] raised_o
);
  logic [N_LINES-1:0] ack_hit;

  irq_mode_reg #(.N_LINES(N_LINES), .TRIG_WMASK(TRIG_WMASK)) u_mode (
    .clk(clk), .rst(rst), .we(mode_we), .wdata(mode_wdata), .mode_q(mode_o)
  );

  irq_ack_decode #(.N_LINES(N_LINES)) u_ack (
    .valid(ack_valid), .idx(ack_idx), .hit(ack_hit)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk(clk), .rst(rst), .req(req_i[g]),
      .mode(trig_mode_e'(mode_o[g])), .ack_hit(ack_hit[g]),
      .init(init_pulse), .mask(mask_i[g]),
      .pend_q(pending_o[g]), .raised_q(raised_o[g])
    );
  end
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] TRIG_WMASK = 8'hF8,
  localparam int                IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] req_i,
  input logic [N_LINES-1:0] mask_i,
  input logic               ack_valid,
  input logic               init_pulse,
  input logic [N_LINES-1:0] pending_o,
  input logic [N_LINES-1:0] mode_o,
  input logic [N_LINES-1:0] raised_o
);
  // R1: level lines mirror the sampled request
  a_r1_level_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(init_pulse)) |->
      ((pending_o & $past(mode_o)) == ($past(req_i) & $past(mode_o))));

  // R3: edge pending bits only drop on acknowledge or init
  a_r3_edge_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(init_pulse) && !$past(ack_valid)) |->
      ((~$past(mode_o) & $past(pending_o) & ~pending_o) == '0));

  // R5: init leaves no edge line pending
  a_r5_init_clears_edge: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(init_pulse)) |-> ((pending_o & ~$past(mode_o)) == '0));

  // R6: mode register never holds a non-writable bit
  a_r6_mode_wmask: assert property (@(posedge clk) disable iff (rst)
    (mode_o & ~TRIG_WMASK) == '0);

  // R7: no raised flag for a masked line, and a raised flag implies pending
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((raised_o & $past(mask_i)) == '0));
  a_r7_raised_pending: assert property (@(posedge clk) disable iff (rst)
    (raised_o & ~pending_o) == '0);
endmodule

bind irq_req_latch irq_req_latch_chk #(.N_LINES(N_LINES), .TRIG_WMASK(TRIG_WMASK)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_i), .ack_valid(ack_valid),
  .init_pulse(init_pulse), .pending_o(pending_o), .mode_o(mode_o), .raised_o(raised_o)
);

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, wdata = '0, mask = '0;
  logic we = 1'b0, ackv = 1'b0, init = 1'b0;
  logic [2:0] aidx = '0;
  logic [N-1:0] pend, mode, raised, pend2, mode2, raised2;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_req_latch #(.N_LINES(N), .TRIG_WMASK(8'hF8)) dut (
    .clk(clk), .rst(rst), .req_i(req), .mode_we(we), .mode_wdata(wdata),
    .mask_i(mask), .ack_valid(ackv), .ack_idx(aidx), .init_pulse(init),
    .pending_o(pend), .mode_o(mode), .raised_o(raised)
  );

  irq_req_latch #(.N_LINES(N), .TRIG_WMASK(8'hDE)) dut_sec (
    .clk(clk), .rst(rst), .req_i('0), .mode_we(we), .mode_wdata(wdata),
    .mask_i('0), .ack_valid(1'b0), .ack_idx(3'd0), .init_pulse(1'b0),
    .pending_o(pend2), .mode_o(mode2), .raised_o(raised2)
  );

  // advance one rising edge; return at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; req = 8'hFF; tick(); tick();
    check("R8 pending after reset", pend, 8'h00);
    check("R8 mode after reset", mode, 8'h00);
    check("R8 raised after reset", raised, 8'h00);
    req = '0; rst = 1'b0; tick();
  endtask

  task automatic t_mode();
    we = 1'b1; wdata = 8'hFF; tick(); we = 1'b0;
    check("R6 primary mask", mode, 8'hF8);
    check("R6 secondary mask", mode2, 8'hDE);
    we = 1'b1; wdata = 8'h0F; tick(); we = 1'b0;
    check("R6 line3 level only", mode, 8'h08);
  endtask

  task automatic t_level();
    req[3] = 1'b1; tick();
    check("R1 level sets", pend, 8'h08);
    check("R7 raised pulse", raised, 8'h08);
    tick();
    check("R7 raised one cycle", raised, 8'h00);
    check("R1 level stays", pend, 8'h08);
    req[3] = 1'b0; tick();
    check("R1 level clears", pend, 8'h00);
  endtask

  task automatic t_edge();
    req[0] = 1'b1; tick();
    check("R2 edge sets", pend, 8'h01);
    ackv = 1'b1; aidx = 3'd0; tick(); ackv = 1'b0;
    check("R4 ack clears edge", pend, 8'h00);
    tick();
    check("R2 held high no relatch", pend, 8'h00);
    req[0] = 1'b0; tick();
    req[0] = 1'b1; tick();
    check("R2 second edge", pend, 8'h01);
    req[0] = 1'b0; tick(); tick();
    check("R3 low keeps edge pending", pend, 8'h01);
  endtask

  task automatic t_ack_level();
    req[3] = 1'b1; tick();
    ackv = 1'b1; aidx = 3'd3; tick(); ackv = 1'b0;
    check("R4 ack keeps level and other lines", pend, 8'h09);
  endtask

  task automatic t_mask();
    mask[1] = 1'b1; req[1] = 1'b1; tick();
    check("R7 masked pending still sets", pend, 8'h0B);
    check("R7 masked raised quiet", raised, 8'h00);
    mask[1] = 1'b0;
  endtask

  task automatic t_init();
    init = 1'b1; tick(); init = 1'b0;
    check("R5 init keeps level drops edge", pend, 8'h08);
    tick();
    check("R5 held-high edge relatches", pend, 8'h0A);
    check("R7 raised after init relatch", raised, 8'h02);
  endtask

  task automatic t_ack_race();
    req[2] = 1'b1; tick();
    req[2] = 1'b0; tick();
    check("R4 line2 pending", pend, 8'h0E);
    req[2] = 1'b1; ackv = 1'b1; aidx = 3'd2; tick(); ackv = 1'b0;
    check("R4 same-cycle edge wins", pend, 8'h0E);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_mode();
        t_level();
        t_edge();
        t_ack_level();
        t_mask();
        t_init();
        t_ack_race();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule